// File: doc/BRIEF.md
# Audio Sample-Rate Window Classifier

This block works out which of seven standard audio sample rates is present by timing a strobe running at 128 times the sample rate against a 216 MHz reference clock. It counts reference cycles across eight strobe periods, which is the span from one rising strobe edge to the eighth edge after it. It then looks up the count in seven programmable windows, one per rate. The windows are narrow for the fast rates and wide for the slow ones, because a fast rate gives a small count.

A rate is reported only once two measurements in a row land in the same window. After that it is held through short disturbances. It is dropped only after a programmable number of consecutive measurements miss the locked window. A separate flag reports that the latest measurement matched no window at all. The strobe is asynchronous to the reference clock and is synchronised inside the block.

Top module: `aud_rate_classifier`

## Requirements
- R1: After reset, rate_code is 0 and both rate_valid and rate_unknown are 0.
- R2: A measurement is the exact number of reference cycles from a rising strobe edge to the eighth rising edge after it. Each closing edge opens the next measurement. A window matches when low <= count <= high, with both bounds inclusive.
- R3: At reset, window k holds nominal ± delta. The nominal value is floor(8·216e6 / (128·fs)), and delta is 9 for fs <= 48 kHz, 6 for 48 kHz < fs <= 96 kHz, and 2 above 96 kHz. Indices 0..6 stand for 32, 44.1, 48, 88.2, 96, 176.4 and 192 kHz. A locked window k gives rate_code k+1, and rate_code is nonzero exactly while rate_valid is 1.
- R4: While no rate is held, rate_valid rises only when two consecutive measurements hit the same window. One measurement alone, or two hits in different windows, leave rate_valid at 0.
- R5: rate_unknown is 1 when the latest measurement matched no window, and returns to 0 on the next measurement that matches one.
- R6: A held rate survives up to miss_limit−1 consecutive measurements that do not hit its window. The miss_limit-th such measurement clears rate_valid and sets rate_code to 0. A hit on the held window resets the miss count. A miss_limit of 0 acts as 1.
- R7: A write with wr_addr 0..6 loads window wr_addr, taking the low bound from wr_data[11:0] and the high bound from wr_data[27:16]. A write with wr_addr 7 has no effect.
- R8: When windows overlap, the lowest index that matches is the one used.
- R9: The cycle count saturates at 4095 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 216 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_128fs | input | 1 | Asynchronous strobe at 128 × sample rate |
| miss_limit | input | 8 | Consecutive misses that drop a held rate (nominal 9) |
| wr_en | input | 1 | Window register write strobe |
| wr_addr | input | 3 | Window index to write |
| wr_data | input | 32 | Low bound in [11:0], high bound in [27:16] |
| rate_code | output | 3 | Detected rate code, 0 when none is held |
| rate_valid | output | 1 | A rate is held |
| rate_unknown | output | 1 | The latest measurement matched no window |

## Verification
The hardest state to reach is a held rate that has absorbed exactly one miss fewer than the limit. That state calls for a precise count of whole measurement spans, with no stray span closing in between. The bench therefore drives the strobe as a continuous train in which each group of eight periods adds up to an exact cycle count, spreading any remainder across the periods. It checks the outputs inside the first period of the following group, which closes each span cycle-accurately. In this way it can place counts on both edges of a window and walk the miss counter up to its limit.

// File: rtl/aud_rate_pkg.sv
package aud_rate_pkg;
  localparam int unsigned RATE_NUM = 7;
  localparam int unsigned IDX_W    = $clog2(RATE_NUM + 1);
  localparam int unsigned LO_LSB   = 0;
  localparam int unsigned HI_LSB   = 16;

  function automatic longint unsigned rate_hz(input int unsigned idx);
    case (idx)
      0: rate_hz = 32000;
      1: rate_hz = 44100;
      2: rate_hz = 48000;
      3: rate_hz = 88200;
      4: rate_hz = 96000;
      5: rate_hz = 176400;
      default: rate_hz = 192000;
    endcase
  endfunction

  function automatic int unsigned nominal_cnt(input longint unsigned ref_hz,
                                              input int unsigned idx);
    nominal_cnt = int'((8 * ref_hz) / (128 * rate_hz(idx)));
  endfunction

  function automatic int unsigned half_width(input int unsigned idx);
    if (rate_hz(idx) > 96000)      half_width = 2;
    else if (rate_hz(idx) > 48000) half_width = 6;
    else                           half_width = 9;
  endfunction
endpackage

// File: rtl/ars_sync_edge.sv
module ars_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // a strobe edge yields one single-cycle pulse (R2)
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ars_span_counter.sv
module ars_span_counter #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned SPAN_EDGES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             done_o
);
  localparam int unsigned EW = (SPAN_EDGES > 1) ? $clog2(SPAN_EDGES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [EW-1:0] EDGE_LAST = EW'(SPAN_EDGES - 1);

  logic             armed_q, armed_d;
  logic [EW-1:0]    edge_q, edge_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0] meas_q, meas_d;
  logic             done_q, done_d;
  logic             cnt_en;

  assign cnt_en  = armed_q;
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    armed_d = armed_q;
    edge_d  = edge_q;
    cnt_d   = cnt_q;
    meas_d  = meas_q;
    done_d  = 1'b0;
    if (rise_i && !armed_q) begin
      armed_d = 1'b1;
      edge_d  = '0;
      cnt_d   = CNT_W'(1);
    end else if (cnt_en) begin
      cnt_d = cnt_inc;
      if (rise_i) begin
        if (edge_q == EDGE_LAST) begin
          meas_d = cnt_q;
          done_d = 1'b1;
          edge_d = '0;
          cnt_d  = CNT_W'(1);
        end else begin
          edge_d = edge_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      edge_q  <= '0;
      cnt_q   <= '0;
      meas_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      edge_q  <= edge_d;
      cnt_q   <= cnt_d;
      meas_q  <= meas_d;
      done_q  <= done_d;
    end
  end

  assign meas_o = meas_q;
  assign done_o = done_q;

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cnt_q == CNT_MAX && !rise_i) |=> cnt_q == CNT_MAX);
  assert_done_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(rise_i));
endmodule

// File: rtl/ars_window_bank.sv
module ars_window_bank
  import aud_rate_pkg::*;
#(
  parameter longint unsigned REF_HZ = 216000000,
  parameter int unsigned     CNT_W  = 12,
  parameter int unsigned     DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  meas_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned FLAT_W = RATE_NUM * 2 * CNT_W;

  logic [RATE_NUM-1:0] in_win;
  logic [FLAT_W-1:0]   win_flat;
  logic                unused_bits;

  assign unused_bits = ^wr_data;

  for (genvar gi = 0; gi < RATE_NUM; gi++) begin : g_win
    localparam int unsigned NOM = nominal_cnt(REF_HZ, gi);
    localparam int unsigned DLT = half_width(gi);
    logic [CNT_W-1:0] lo_q, lo_d, hi_q, hi_d;
    logic             sel;

    assign sel = wr_en && (wr_addr == IDX_W'(gi));

    always_comb begin
      lo_d = lo_q;
      hi_d = hi_q;
      if (sel) begin
        lo_d = wr_data[LO_LSB +: CNT_W];
        hi_d = wr_data[HI_LSB +: CNT_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= CNT_W'(NOM - DLT);
        hi_q <= CNT_W'(NOM + DLT);
      end else begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
    end

    assign in_win[gi] = (meas_i >= lo_q) && (meas_i <= hi_q);
    assign win_flat[gi*2*CNT_W +: 2*CNT_W] = {hi_q, lo_q};
  end

  always_comb begin
    idx_o = '0;
    for (int k = RATE_NUM - 1; k >= 0; k--)
      if (in_win[k]) idx_o = IDX_W'(k);
  end

  assign hit_o = |in_win;

  assert_hit_member_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> in_win[idx_o]);
  assert_bad_addr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= IDX_W'(RATE_NUM)) |=> $stable(win_flat));
endmodule

// File: rtl/aud_rate_classifier.sv
module aud_rate_classifier
  import aud_rate_pkg::*;
#(
  parameter longint unsigned REF_HZ      = 216000000,
  parameter int unsigned     CNT_W       = 12,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter int unsigned     SPAN_EDGES  = 8,
  parameter int unsigned     DATA_W      = 32,
  parameter int unsigned     TOL_W       = 8
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              strobe_128fs,
  input  logic [TOL_W-1:0]  miss_limit,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [IDX_W-1:0]  rate_code,
  output logic              rate_valid,
  output logic              rate_unknown
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  logic             rise_w, done_w, hit_w;
  logic [CNT_W-1:0] meas_w;
  logic [IDX_W-1:0] idx_w;

  ars_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk_ref), .rst_n(rst_n_i), .async_in(strobe_128fs), .rise_o(rise_w));

  ars_span_counter #(.CNT_W(CNT_W), .SPAN_EDGES(SPAN_EDGES)) i_span (
    .clk(clk_ref), .rst_n(rst_n_i), .rise_i(rise_w),
    .meas_o(meas_w), .done_o(done_w));

  ars_window_bank #(.REF_HZ(REF_HZ), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_bank (
    .clk(clk_ref), .rst_n(rst_n_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .meas_i(meas_w), .hit_o(hit_w), .idx_o(idx_w));

  logic             prev_hit_q, prev_hit_d;
  logic [IDX_W-1:0] prev_idx_q, prev_idx_d;
  logic             lock_q, lock_d;
  logic [IDX_W-1:0] lock_idx_q, lock_idx_d;
  logic [IDX_W-1:0] code_q, code_d;
  logic [TOL_W-1:0] miss_q, miss_d;
  logic             unk_q, unk_d;
  logic [TOL_W-1:0] tol_eff;
  logic [TOL_W:0]   miss_next;

  assign tol_eff   = (miss_limit == '0) ? TOL_W'(1) : miss_limit;
  assign miss_next = {1'b0, miss_q} + 1'b1;

  always_comb begin
    prev_hit_d = prev_hit_q;
    prev_idx_d = prev_idx_q;
    lock_d     = lock_q;
    lock_idx_d = lock_idx_q;
    code_d     = code_q;
    miss_d     = miss_q;
    unk_d      = unk_q;
    if (done_w) begin
      prev_hit_d = hit_w;
      prev_idx_d = idx_w;
      unk_d      = !hit_w;
      if (lock_q) begin
        if (hit_w && idx_w == lock_idx_q) begin
          miss_d = '0;
        end else if (miss_next >= {1'b0, tol_eff}) begin
          lock_d = 1'b0;
          code_d = '0;
          miss_d = '0;
        end else begin
          miss_d = miss_next[TOL_W-1:0];
        end
      end else if (hit_w && prev_hit_q && idx_w == prev_idx_q) begin
        lock_d     = 1'b1;
        lock_idx_d = idx_w;
        code_d     = idx_w + 1'b1;
        miss_d     = '0;
      end
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n_i) begin
    if (!rst_n_i) begin
      prev_hit_q <= 1'b0;
      prev_idx_q <= '0;
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
      code_q     <= '0;
      miss_q     <= '0;
      unk_q      <= 1'b0;
    end else begin
      prev_hit_q <= prev_hit_d;
      prev_idx_q <= prev_idx_d;
      lock_q     <= lock_d;
      lock_idx_q <= lock_idx_d;
      code_q     <= code_d;
      miss_q     <= miss_d;
      unk_q      <= unk_d;
    end
  end

  assign rate_code    = code_q;
  assign rate_valid   = lock_q;
  assign rate_unknown = unk_q;

  assert_code_tracks_valid_R3: assert property (@(posedge clk_ref) disable iff (!rst_n_i)
    rate_valid == (rate_code != '0));
  assert_lock_needs_pair_R4: assert property (@(posedge clk_ref) disable iff (!rst_n_i)
    $rose(lock_q) |-> $past(done_w && hit_w && prev_hit_q));
  assert_unknown_on_measure_R5: assert property (@(posedge clk_ref) disable iff (!rst_n_i)
    !$past(done_w) |-> $stable(unk_q));
  assert_drop_on_measure_R6: assert property (@(posedge clk_ref) disable iff (!rst_n_i)
    $fell(lock_q) |-> $past(done_w));
  assert_miss_bound_R6: assert property (@(posedge clk_ref) disable iff (!rst_n_i)
    lock_q |-> miss_q < tol_eff);
endmodule

// File: tb/test_aud_rate_classifier.sv
module test_aud_rate_classifier;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobe;
  logic [7:0] miss_limit;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [31:0] wr_data;
  logic [2:0] rate_code;
  logic       rate_valid, rate_unknown;

  int n_chk = 0;
  int n_fail = 0;

  bit    have_prev;
  bit    exp_v, exp_u;
  int    exp_c;
  string exp_tag;

  always #2 clk = ~clk;

  aud_rate_classifier i_aud_rate_classifier (
    .clk_ref(clk), .rst_n(rst_n), .strobe_128fs(strobe), .miss_limit(miss_limit),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rate_code(rate_code), .rate_valid(rate_valid), .rate_unknown(rate_unknown));

  function automatic longint fs_of(int i);
    case (i)
      0: return 32000;   1: return 44100;  2: return 48000;
      3: return 88200;   4: return 96000;  5: return 176400;
      default: return 192000;
    endcase
  endfunction
  function automatic int nom_of(int i);
    return int'((64'd8 * 64'd216000000) / (64'd128 * fs_of(i)));
  endfunction
  function automatic int dlt_of(int i);
    return (fs_of(i) > 96000) ? 2 : (fs_of(i) > 48000) ? 6 : 9;
  endfunction

  task automatic finish_up();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_up();
  end

  task automatic check_out(string tag, bit v, int c, bit u);
    n_chk++;
    if (rate_valid !== v || rate_code !== 3'(c) || rate_unknown !== u) begin
      n_fail++;
      $display("FAIL %s: actual code=%0d valid=%0d unk=%0d expected code=%0d valid=%0d unk=%0d",
               tag, rate_code, rate_valid, rate_unknown, c, v, u);
    end
  endtask

  // eight strobe periods summing to exactly span cycles; edge at period start
  task automatic drive_group(int span);
    for (int k = 0; k < 8; k++) begin
      int p;
      p = ((k + 1) * span) / 8 - (k * span) / 8;
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        strobe = (c < 3);
        if (k == 0 && c == 6 && have_prev) check_out(exp_tag, exp_v, exp_c, exp_u);
      end
    end
  endtask

  task automatic step(int span, bit v, int c, bit u, string tag);
    drive_group(span);
    have_prev = 1'b1;
    exp_v = v; exp_c = c; exp_u = u; exp_tag = tag;
  endtask

  task automatic flush();
    drive_group(100);
    have_prev = 1'b0;
  endtask

  task automatic do_reset(int tol);
    strobe = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    miss_limit = 8'(tol);
    have_prev = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(int addr, int lo, int hi);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr);
    wr_data = {4'h0, 12'(hi), 4'h0, 12'(lo)};
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0a1d));
    do_reset(9);
    check_out("R1 reset state", 0, 0, 0);

    // R3: every default window at its nominal count
    for (int i = 0; i < 7; i++) begin
      do_reset(9);
      step(nom_of(i), 0, 0, 0, "R4 single measurement");
      step(nom_of(i), 1, i + 1, 0, "R3 default window");
      flush();
    end

    // R2: inclusive lower bound of window 1 (297) and just outside
    do_reset(9);
    step(297, 0, 0, 0, "R4 single");
    step(297, 1, 2, 0, "R2 count equals low bound");
    flush();
    do_reset(9);
    step(296, 0, 0, 1, "R2 one below low bound");
    step(316, 0, 0, 1, "R2 one above high bound");
    flush();

    // R4: hits in two different windows do not lock
    do_reset(9);
    step(421, 0, 0, 0, "R4 first");
    step(306, 0, 0, 0, "R4 different window");
    step(306, 1, 2, 0, "R4 pair in window 1");
    flush();

    // R5: unknown set and cleared
    do_reset(9);
    step(200, 0, 0, 1, "R5 no window");
    step(140, 0, 0, 0, "R5 cleared on hit");
    step(140, 1, 5, 0, "R5 then lock");
    flush();

    // R6: limit 9, eight misses hold, ninth drops, then relock
    do_reset(9);
    step(281, 0, 0, 0, "R6 pre");
    step(281, 1, 3, 0, "R6 locked");
    for (int m = 0; m < 8; m++) step(421, 1, 3, 0, "R6 hold under limit");
    step(421, 0, 0, 0, "R6 drop at limit");
    step(421, 1, 1, 0, "R4 relock after drop");
    flush();

    // R6: limit 0 acts as 1
    do_reset(0);
    step(153, 0, 0, 0, "R6 pre");
    step(153, 1, 4, 0, "R6 locked");
    step(200, 0, 0, 1, "R6 limit zero drops at once");
    flush();

    // R6: limit 2, a hit clears the miss count
    do_reset(2);
    step(70, 0, 0, 0, "R6 pre");
    step(70, 1, 7, 0, "R6 locked 192k");
    step(76, 1, 7, 0, "R6 first miss");
    step(70, 1, 7, 0, "R6 hit clears count");
    step(76, 1, 7, 0, "R6 miss after clear");
    step(76, 0, 0, 0, "R6 second miss drops");
    flush();

    // R7: address 7 ignored, window 0 rewritten
    do_reset(9);
    wr(7, 195, 205);
    wr(0, 500, 520);
    step(200, 0, 0, 1, "R7 address 7 write ignored");
    step(510, 0, 0, 0, "R7 new window 0 hit");
    step(510, 1, 1, 0, "R7 lock on written window");
    step(421, 1, 1, 1, "R7 old window 0 range gone");
    flush();

    // R8: overlapping windows, lowest index wins
    do_reset(9);
    wr(3, 270, 290);
    step(281, 0, 0, 0, "R8 pre");
    step(281, 1, 3, 0, "R8 lowest index priority");
    flush();

    // R9: saturation at 4095
    do_reset(9);
    wr(6, 4090, 4095);
    step(5000, 0, 0, 0, "R9 pre");
    step(5000, 1, 7, 0, "R9 count saturates");
    flush();

    // random rates with jitter inside each window
    for (int t = 0; t < 20; t++) begin
      int i, d, s1, s2;
      i  = int'($urandom % 7);
      d  = dlt_of(i);
      s1 = nom_of(i) - d + int'($urandom % (2 * d + 1));
      s2 = nom_of(i) - d + int'($urandom % (2 * d + 1));
      do_reset(9);
      step(s1, 0, 0, 0, "R4 random first");
      step(s2, 1, i + 1, 0, "R3 random jittered rate");
      flush();
    end

    finish_up();
  end
endmodule